// File: doc/BRIEF.md
# Audio Clock Regeneration Parameter Unit

This block works out the audio clock regeneration pair, the 20-bit divider N and the 20-bit cycle count CTS, for a configured TMDS pixel clock. A start strobe takes a snapshot of a 32-bit pixel frequency in hertz. The block then walks a fixed sixteen-entry rate table, checking one entry per clock. The first entry whose frequency is at or above the request wins, and its N and CTS appear on the committed outputs. A request above the fastest entry raises an unsupported flag and leaves audio disabled, so valid stays low.

Software can also set N and CTS through six byte-wide shadow registers. The committed outputs change only in a single clock, and only when the N low byte is written while the atomic flag is held in the N top register. A partly written set of bytes therefore never reaches the outputs.

Top module: `acr_param_unit`

## Requirements
- R1: After reset, n_out, cts_out, cts_manual and n_shift are zero, and valid, unsupported and done are low.
- R2: A start pulse captures pix_hz and clears done, valid and unsupported on the next clock. Table entry i, counted from 0, is examined i+1 clocks after the start edge. On a match, done and valid rise after that edge and the entry's N and CTS appear on n_out and cts_out.
- R3: If pix_hz is greater than 297000000, unsupported and done rise 16 clocks after the start edge. valid stays low and n_out and cts_out keep their previous values. valid and unsupported are never high together.
- R4: The regular entries all use N = 6144, with CTS equal to the entry frequency in kHz. The entry frequencies in hertz are 25175000, 25200000, 27000000, 27027000, 40000000, 54000000, 54054000, 65000000, 74250000, 83500000, 106500000, 108000000 and 148500000.
- R5: The fractional entries are exceptions. 74176000 Hz uses N 11648 and CTS 140625. 148352000 Hz uses N 5824 and CTS 140625. 297000000 Hz uses N 5120 and CTS 247500.
- R6: A start pulse during a search abandons it and begins a new search from entry 0 with the new pix_hz.
- R7: Byte register addresses are as follows: 0 is N[7:0], 1 is N[15:8], 2 is N top (bits 3:0 are N[19:16], bit 7 is the atomic flag), 3 is CTS[7:0], 4 is CTS[15:8], and 5 is CTS top. A write to address 0 while the atomic flag is set copies all shadow values, together with this N low byte, to the outputs in one clock.
- R8: Writes to addresses 1 to 5 do not change the outputs. A write to address 0 while the atomic flag is clear does not change the outputs either.
- R9: In the CTS top register, bits 3:0 are CTS[19:16], bit 4 is the manual-CTS enable and bits 6:5 are the N-shift field. The enable and the field reach cts_manual and n_shift only on a commit.
- R10: A request exactly equal to an entry frequency selects that entry. A request one hertz above it selects the next entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_hz | input | 32 | Requested pixel clock in Hz |
| start | input | 1 | Start a table search |
| wr_en | input | 1 | Byte register write strobe |
| wr_addr | input | 3 | Byte register address |
| wr_data | input | 8 | Byte register write data |
| n_out | output | 20 | Committed N |
| cts_out | output | 20 | Committed CTS |
| cts_manual | output | 1 | Committed manual-CTS enable |
| n_shift | output | 2 | Committed N-shift field |
| valid | output | 1 | Last search found an entry |
| unsupported | output | 1 | Last search found no entry |
| done | output | 1 | Last search finished |

## Verification
The properties assume that reset is held low for at least one clock edge. They also assume that a commit write is only expected to land when no search is running, because a search that finishes in the same clock takes priority over the write. The stimulus keeps register writes and searches apart in time. It pulses start for a single clock and holds pix_hz steady for the whole of each search.

// File: rtl/acr_param_unit.sv
module acr_param_unit #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   pix_hz,
  input  logic          start,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output logic [19:0]   n_out,
  output logic [19:0]   cts_out,
  output logic          cts_manual,
  output logic [1:0]    n_shift,
  output logic          valid,
  output logic          unsupported,
  output logic          done
);
  localparam int NUM_ENT = 16;
  localparam int IW = $clog2(NUM_ENT);
  localparam int VW = 20;
  localparam int EW = 32 + 2 * VW;

  function automatic logic [EW-1:0] entry(input logic [IW-1:0] i);
    case (i)
      4'd0:    entry = {32'd25175000,  20'd6144,  20'd25175};
      4'd1:    entry = {32'd25200000,  20'd6144,  20'd25200};
      4'd2:    entry = {32'd27000000,  20'd6144,  20'd27000};
      4'd3:    entry = {32'd27027000,  20'd6144,  20'd27027};
      4'd4:    entry = {32'd40000000,  20'd6144,  20'd40000};
      4'd5:    entry = {32'd54000000,  20'd6144,  20'd54000};
      4'd6:    entry = {32'd54054000,  20'd6144,  20'd54054};
      4'd7:    entry = {32'd65000000,  20'd6144,  20'd65000};
      4'd8:    entry = {32'd74176000,  20'd11648, 20'd140625};
      4'd9:    entry = {32'd74250000,  20'd6144,  20'd74250};
      4'd10:   entry = {32'd83500000,  20'd6144,  20'd83500};
      4'd11:   entry = {32'd106500000, 20'd6144,  20'd106500};
      4'd12:   entry = {32'd108000000, 20'd6144,  20'd108000};
      4'd13:   entry = {32'd148352000, 20'd5824,  20'd140625};
      4'd14:   entry = {32'd148500000, 20'd6144,  20'd148500};
      default: entry = {32'd297000000, 20'd5120,  20'd247500};
    endcase
  endfunction

  logic [31:0]   req;
  logic [IW-1:0] idx;
  logic          busy;
  logic [EW-1:0] ent;
  logic          hit, last;

  logic [7:0] sh_n_mid, sh_cts_lo, sh_cts_mid;
  logic [3:0] sh_n_top, sh_cts_top;
  logic       atomic, sh_man;
  logic [1:0] sh_shift;
  logic       commit;

  assign ent    = entry(idx);
  assign hit    = busy && (req <= ent[EW-1 -: 32]);
  assign last   = (idx == IW'(NUM_ENT - 1));
  assign commit = wr_en && (wr_addr == AW'(0)) && atomic;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_n_mid <= '0; sh_n_top <= '0; atomic <= 1'b0;
      sh_cts_lo <= '0; sh_cts_mid <= '0; sh_cts_top <= '0;
      sh_man <= 1'b0; sh_shift <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(1): sh_n_mid <= wr_data;
        AW'(2): begin sh_n_top <= wr_data[3:0]; atomic <= wr_data[7]; end
        AW'(3): sh_cts_lo <= wr_data;
        AW'(4): sh_cts_mid <= wr_data;
        AW'(5): begin
          sh_cts_top <= wr_data[3:0];
          sh_man     <= wr_data[4];
          sh_shift   <= wr_data[6:5];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req <= '0; idx <= '0; busy <= 1'b0;
      valid <= 1'b0; unsupported <= 1'b0; done <= 1'b0;
      n_out <= '0; cts_out <= '0; cts_manual <= 1'b0; n_shift <= '0;
    end else begin
      if (commit) begin
        n_out      <= {sh_n_top, sh_n_mid, wr_data};
        cts_out    <= {sh_cts_top, sh_cts_mid, sh_cts_lo};
        cts_manual <= sh_man;
        n_shift    <= sh_shift;
      end
      if (start) begin
        req <= pix_hz; idx <= '0; busy <= 1'b1;
        valid <= 1'b0; unsupported <= 1'b0; done <= 1'b0;
      end else if (hit) begin
        busy <= 1'b0; done <= 1'b1; valid <= 1'b1;
        n_out   <= ent[2*VW-1 -: VW];
        cts_out <= ent[VW-1:0];
      end else if (busy && last) begin
        busy <= 1'b0; done <= 1'b1; unsupported <= 1'b1;
      end else if (busy) begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

module acr_param_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        atomic,
  input logic        busy,
  input logic [19:0] n_out,
  input logic [19:0] cts_out,
  input logic        valid,
  input logic        unsupported,
  input logic        done
);
  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && unsupported));

  assert_valid_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> done);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done && !valid && !unsupported);

  assert_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0 && atomic && !busy) |=> n_out[7:0] == $past(wr_data));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_addr == 3'd0 && atomic) && !busy) |=> ($stable(n_out) && $stable(cts_out)));
endmodule

bind acr_param_unit acr_param_unit_chk u_chk (.*);

// File: tb/acr_param_unit_test.sv
module acr_param_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] pix_hz = '0;
  logic start = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [19:0] n_out, cts_out;
  logic cts_manual, valid, unsupported, done;
  logic [1:0] n_shift;

  int checks = 0, fails = 0;
  bit finished = 0;

  acr_param_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int unsigned hz_list [16] = '{25175000, 25200000, 27000000, 27027000,
    40000000, 54000000, 54054000, 65000000, 74176000, 74250000, 83500000,
    106500000, 108000000, 148352000, 148500000, 297000000};

  function automatic int ref_n(int unsigned hz);
    if (hz == 74176000) return 11648;
    if (hz == 148352000) return 5824;
    if (hz == 297000000) return 5120;
    return 6144;
  endfunction

  function automatic int ref_cts(int unsigned hz);
    if (hz == 74176000 || hz == 148352000) return 140625;
    if (hz == 297000000) return 247500;
    return hz / 1000;
  endfunction

  // behavioural reference model
  int m_n, m_cts, m_man, m_shift, m_valid, m_uns, m_done;
  int m_count, m_idx;
  int s_nmid, s_ntop, s_atom, s_clo, s_cmid, s_ctop, s_man, s_shift;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_n = 0; m_cts = 0; m_man = 0; m_shift = 0;
      m_valid = 0; m_uns = 0; m_done = 0; m_count = 0; m_idx = -1;
      s_nmid = 0; s_ntop = 0; s_atom = 0; s_clo = 0; s_cmid = 0;
      s_ctop = 0; s_man = 0; s_shift = 0;
    end else begin
      if (wr_en) begin
        if (wr_addr == 0 && s_atom) begin
          m_n = s_ntop * 65536 + s_nmid * 256 + wr_data;
          m_cts = s_ctop * 65536 + s_cmid * 256 + s_clo;
          m_man = s_man; m_shift = s_shift;
        end
        if (wr_addr == 1) s_nmid = wr_data;
        if (wr_addr == 2) begin s_ntop = wr_data % 16; s_atom = wr_data / 128; end
        if (wr_addr == 3) s_clo = wr_data;
        if (wr_addr == 4) s_cmid = wr_data;
        if (wr_addr == 5) begin
          s_ctop = wr_data % 16; s_man = (wr_data / 16) % 2; s_shift = (wr_data / 32) % 4;
        end
      end
      if (m_count > 0) begin
        m_count--;
        if (m_count == 0) begin
          m_done = 1;
          if (m_idx >= 0) begin
            m_valid = 1; m_n = ref_n(hz_list[m_idx]); m_cts = ref_cts(hz_list[m_idx]);
          end else m_uns = 1;
        end
      end
      if (start) begin
        m_idx = -1;
        for (int i = 15; i >= 0; i--) if (pix_hz <= hz_list[i]) m_idx = i;
        m_count = (m_idx >= 0) ? m_idx + 1 : 16;
        m_done = 0; m_valid = 0; m_uns = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      checks++;
      if (n_out != 20'(m_n) || cts_out != 20'(m_cts) || valid != m_valid[0] ||
          unsupported != m_uns[0] || done != m_done[0] ||
          cts_manual != m_man[0] || n_shift != 2'(m_shift)) begin
        fails++;
        $display("FAIL R2/R7 model t=%0t: n=%0d cts=%0d v=%0b u=%0b d=%0b exp n=%0d cts=%0d v=%0d u=%0d d=%0d",
                 $time, n_out, cts_out, valid, unsupported, done, m_n, m_cts, m_valid, m_uns, m_done);
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic go(int unsigned hz);
    @(negedge clk); pix_hz = hz; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3); rst_n = 1'b1; cyc(1);
    // R1 reset state
    check("R1 n", n_out, 0); check("R1 cts", cts_out, 0);
    check("R1 flags", {valid, unsupported, done, cts_manual, n_shift}, 0);

    // R2/R4: 25.2 MHz, entry 1 -> done after 2 clocks
    go(25200000);
    cyc(1); check("R2 done early", done, 0);
    cyc(1); check("R2 done", done, 1); check("R2 valid", valid, 1);
    check("R4 n", n_out, 6144); check("R4 cts", cts_out, 25200);

    go(148500000); cyc(15); check("R4 cts 148.5", cts_out, 148500);

    // R5 fractional exceptions
    go(74176000); cyc(9);
    check("R5 n 74.176", n_out, 11648); check("R5 cts 74.176", cts_out, 140625);
    go(148352000); cyc(14);
    check("R5 n 148.352", n_out, 5824); check("R5 cts 148.352", cts_out, 140625);

    // R10 exact boundary on last entry, and low end
    go(297000000); cyc(16);
    check("R10 n 297", n_out, 5120); check("R10 cts 297", cts_out, 247500);
    go(1); cyc(1); check("R10 lowest", cts_out, 25175);
    go(25175001); cyc(2); check("R10 next", cts_out, 25200);

    // R3 unsupported
    go(297000001);
    cyc(15); check("R3 not yet", done, 0);
    cyc(1); check("R3 uns", unsupported, 1); check("R3 valid", valid, 0);
    check("R3 hold cts", cts_out, 25200);

    // R6 restart mid-search
    go(297000001); cyc(3);
    go(40000000);
    cyc(4); check("R6 early", done, 0);
    cyc(1); check("R6 done", done, 1); check("R6 cts", cts_out, 40000);
    check("R6 uns", unsupported, 0);
    cyc(2);

    // R7/R8/R9 atomic register update
    wr(2, 8'h81); wr(5, 8'h52); wr(4, 8'h34); wr(3, 8'h56); wr(1, 8'hAB);
    check("R8 n held", n_out, 6144); check("R8 cts held", cts_out, 40000);
    check("R9 man held", cts_manual, 0);
    wr(0, 8'hCD);
    check("R7 n", n_out, 20'h1ABCD); check("R7 cts", cts_out, 20'h23456);
    check("R9 man", cts_manual, 1); check("R9 shift", n_shift, 2);

    // R8 no commit without atomic flag
    wr(2, 8'h03); wr(3, 8'h99); wr(0, 8'h11);
    check("R8 no atomic n", n_out, 20'h1ABCD); check("R8 no atomic cts", cts_out, 20'h23456);

    cyc(3);
    finish_run();
  end
endmodule